// File: doc/BRIEF.md
# UART Receive Word Packer

This block is the receive half of a serial port with a small memory-mapped register bus. It deserializes 8N1 characters from a single input line and gathers them four at a time into 32-bit words. Complete words go into a word FIFO that software drains by reading one data offset. Bytes that have not yet made a full word stay in a packing buffer, and software can read how many bytes are waiting there.

A partial word reaches the FIFO only through a stale event. Software can force one with a command, or the block raises one by itself when the line has stayed idle for a programmed number of character times. After a stale event, reception is disarmed until software writes the transfer-length offset. An overrun flag records characters lost because both the packing buffer and the FIFO were full. Command codes clear that flag, clear the stale status and reset the whole receive path.

The receiver is a four-state machine:
- `RX_IDLE` waits for a falling edge (transition *start-seen*).
- `RX_START` checks the line at mid-bit. It goes on to `RX_DATA` (*start-valid*) or returns to `RX_IDLE` (*glitch*).
- `RX_DATA` samples eight bits, least significant first (*eighth-bit* leads to `RX_STOP`).
- `RX_STOP` samples the stop bit and returns to `RX_IDLE` (*frame-end*). It delivers the byte only if the stop bit is high.

Top module: `uart_rx_packer`

## Requirements
- R1: Bytes are packed into a word in arrival order, from the lowest lane up. The first byte goes in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R2: Bit 0 of the status word (offset 0x0A4) is 1 exactly when the word FIFO holds at least one word.
- R3: A read of offset 0x140 returns and removes the oldest FIFO word. When the FIFO is empty, the read returns 0 and changes no state, and the packing level is left as it was.
- R4: Bits [9:7] of offset 0x050 give the number of bytes in the packing buffer, from 0 to 4.
- R5: A command write (offset 0x0A8) with bits [11:8] = 4 raises a stale event. The event moves the partial buffer into the FIFO with its unused upper lanes set to zero, and sets status bit 5.
- R6: A command write with bits [7:4] = 8 clears status bit 5.
- R7: Status bit 4 (overrun) is set in two cases, and the data involved is dropped:
  - a character completes while the buffer holds 4 bytes and the FIFO (16 words) is full;
  - a stale event finds a non-empty buffer and a full FIFO.
  A command write with bits [7:4] = 3 clears the bit.
- R8: After a stale event, completed characters are discarded until a write to offset 0x034 (any value) re-arms reception.
- R9: A command write with bits [7:4] = 1 (for example 0x10) empties the packing buffer and the FIFO, clears the overrun and stale flags, re-arms reception and returns the receiver to idle.
- R10: When offset 0x038 holds N > 0 and the buffer has been non-empty with an idle line for N character times (10 bit times each), a stale event is raised automatically. N = 0 turns this off, and N = 0 is the reset value.
- R11: Characters are 8N1, least significant bit first. A character whose stop bit samples low is discarded.
- R12: A buffer holding four bytes moves into the FIFO as soon as the FIFO has a free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every bit time is CLKS_PER_BIT cycles of it |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |

## Verification
The assertions assume that a single bus access never carries two command codes that conflict, for example a receiver reset combined with a forced stale. They also assume that `rxd` holds each bit for a full bit time, so the mid-bit sample is well defined. The bench meets both assumptions:
- It issues each command as its own write of a single code.
- It drives the line only through a task that holds every bit for exactly CLKS_PER_BIT clocks.
- It leaves at least one idle bit time between characters.
- It drives bus strobes on falling clock edges, away from the sampling edge.

// File: rtl/uart_rxp_pkg.sv
package uart_rxp_pkg;

    localparam int ADDR_W = 9;

    localparam logic [ADDR_W-1:0] OFS_REARM = 9'h034;
    localparam logic [ADDR_W-1:0] OFS_IDLE  = 9'h038;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 9'h050;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 9'h0A4;
    localparam logic [ADDR_W-1:0] OFS_CMD   = 9'h0A8;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 9'h140;

    localparam logic [3:0] CMD_LO_RESET     = 4'h1;
    localparam logic [3:0] CMD_LO_CLR_ERR   = 4'h3;
    localparam logic [3:0] CMD_LO_CLR_STALE = 4'h8;
    localparam logic [3:0] CMD_HI_FORCE     = 4'h4;

    localparam int STAT_READY = 0;
    localparam int STAT_OVR   = 4;
    localparam int STAT_STALE = 5;
    localparam int LEVEL_LSB  = 7;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

endpackage

// File: rtl/uart_rxp_deser.sv
module uart_rxp_deser
    import uart_rxp_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       rxd,
    output logic       busy,
    output logic       byte_done,
    output logic [7:0] byte_val
);
    localparam int CW = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] T_HALF = CW'(CLKS_PER_BIT / 2 - 1);
    localparam logic [CW-1:0] T_LAST = CW'(CLKS_PER_BIT - 1);

    rx_state_t state_q, state_d;
    logic [CW-1:0] tick_q;
    logic [2:0]    bit_q;
    logic [7:0]    shift_q;
    logic          rx_meta, rx_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            rx_meta <= rxd;
            rx_s    <= rx_meta;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= RX_IDLE;
        else if (clr) state_q <= RX_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!rx_s) state_d = RX_START;
            RX_START: if (tick_q == T_HALF) state_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick_q == T_LAST && bit_q == 3'd7) state_d = RX_STOP;
            RX_STOP:  if (tick_q == T_LAST) state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q    <= '0;
            bit_q     <= '0;
            shift_q   <= '0;
            byte_done <= 1'b0;
            byte_val  <= '0;
        end else begin
            byte_done <= 1'b0;
            if (clr) begin
                tick_q <= '0;
                bit_q  <= '0;
            end else begin
                unique case (state_q)
                    RX_IDLE: begin
                        tick_q <= '0;
                        bit_q  <= '0;
                    end
                    RX_START: tick_q <= (tick_q == T_HALF) ? '0 : tick_q + 1'b1;
                    RX_DATA: begin
                        if (tick_q == T_LAST) begin
                            tick_q  <= '0;
                            shift_q <= {rx_s, shift_q[7:1]};
                            bit_q   <= bit_q + 1'b1;
                        end else begin
                            tick_q <= tick_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tick_q == T_LAST) begin
                            tick_q    <= '0;
                            byte_done <= rx_s;
                            byte_val  <= shift_q;
                        end else begin
                            tick_q <= tick_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign busy = (state_q != RX_IDLE);

endmodule

// File: rtl/uart_rxp_fifo.sv
module uart_rxp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    // DEPTH must be a power of two: the wrap bit marks full.
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    always_ff @(posedge clk) begin
        if (push) mem[wp[AW-1:0]] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else if (clr) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign head  = mem[rp[AW-1:0]];

endmodule

// File: rtl/uart_rx_packer.sv
module uart_rx_packer
    import uart_rxp_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int FIFO_DEPTH   = 16,
    parameter int IDLE_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int CHAR_CLKS = 10 * CLKS_PER_BIT;
    localparam int CNT_W     = $clog2((2 ** IDLE_W) * CHAR_CLKS + 1);

    logic        rx_busy, byte_done;
    logic [7:0]  byte_val;
    logic        fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [31:0] fifo_head, push_word;

    logic [2:0]  pack_cnt, cnt_d;
    logic [31:0] pack_buf, buf_d;
    logic        armed, armed_d, ovr_q, stale_q, set_ovr;
    logic [IDLE_W-1:0] idle_lim;
    logic [CNT_W-1:0]  idle_cnt, lim_clks;

    logic wr_cmd, cmd_rst, cmd_clr_err, cmd_clr_stale, cmd_force, rearm;
    logic auto_stale, stale_evt;

    assign wr_cmd        = bus_wr && (bus_addr == OFS_CMD);
    assign cmd_rst       = wr_cmd && (bus_wdata[7:4] == CMD_LO_RESET);
    assign cmd_clr_err   = wr_cmd && (bus_wdata[7:4] == CMD_LO_CLR_ERR);
    assign cmd_clr_stale = wr_cmd && (bus_wdata[7:4] == CMD_LO_CLR_STALE);
    assign cmd_force     = wr_cmd && (bus_wdata[11:8] == CMD_HI_FORCE);
    assign rearm         = bus_wr && (bus_addr == OFS_REARM);

    uart_rxp_deser #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_deser (
        .clk(clk), .rst_n(rst_n), .clr(cmd_rst), .rxd(rxd),
        .busy(rx_busy), .byte_done(byte_done), .byte_val(byte_val)
    );

    uart_rxp_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(cmd_rst),
        .push(fifo_push), .wdata(push_word), .pop(fifo_pop),
        .head(fifo_head), .full(fifo_full), .empty(fifo_empty)
    );

    // Idle timer for the automatic stale event
    assign lim_clks   = CNT_W'(idle_lim) * CNT_W'(CHAR_CLKS);
    assign auto_stale = (idle_lim != '0) && armed && (pack_cnt != 3'd0)
                        && !rx_busy && (idle_cnt == lim_clks - 1'b1);
    assign stale_evt  = cmd_force || auto_stale;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_cnt <= '0;
        else if (cmd_rst || rx_busy || !armed || pack_cnt == 3'd0 || stale_evt)
            idle_cnt <= '0;
        else
            idle_cnt <= idle_cnt + 1'b1;
    end

    // Packer next state
    always_comb begin
        logic [2:0]  base_cnt;
        logic [31:0] base_buf;
        cnt_d     = pack_cnt;
        buf_d     = pack_buf;
        armed_d   = armed;
        fifo_push = 1'b0;
        push_word = pack_buf;
        set_ovr   = 1'b0;
        base_cnt  = pack_cnt;
        base_buf  = pack_buf;
        if (stale_evt) begin
            if (pack_cnt != 3'd0) begin
                if (!fifo_full) fifo_push = 1'b1;
                else            set_ovr   = 1'b1;
            end
            cnt_d   = 3'd0;
            buf_d   = '0;
            armed_d = 1'b0;
        end else begin
            if (pack_cnt == 3'd4 && !fifo_full) begin
                fifo_push = 1'b1;
                base_cnt  = 3'd0;
                base_buf  = '0;
            end
            if (byte_done && armed) begin
                if (base_cnt == 3'd4) begin
                    set_ovr = 1'b1;
                end else begin
                    base_buf[{base_cnt[1:0], 3'b000} +: 8] = byte_val;
                    base_cnt = base_cnt + 3'd1;
                end
            end
            cnt_d = base_cnt;
            buf_d = base_buf;
        end
        if (rearm) armed_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pack_cnt <= '0;
            pack_buf <= '0;
            armed    <= 1'b1;
            ovr_q    <= 1'b0;
            stale_q  <= 1'b0;
            idle_lim <= '0;
        end else if (cmd_rst) begin
            pack_cnt <= '0;
            pack_buf <= '0;
            armed    <= 1'b1;
            ovr_q    <= 1'b0;
            stale_q  <= 1'b0;
        end else begin
            pack_cnt <= cnt_d;
            pack_buf <= buf_d;
            armed    <= armed_d;
            if (set_ovr)          ovr_q <= 1'b1;
            else if (cmd_clr_err) ovr_q <= 1'b0;
            if (stale_evt)          stale_q <= 1'b1;
            else if (cmd_clr_stale) stale_q <= 1'b0;
            if (bus_wr && bus_addr == OFS_IDLE) idle_lim <= bus_wdata[IDLE_W-1:0];
        end
    end

    // Register read port
    assign fifo_pop = bus_rd && (bus_addr == OFS_DATA) && !fifo_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= '0;
            unique case (bus_addr)
                OFS_DATA:  bus_rdata <= fifo_empty ? '0 : fifo_head;
                OFS_LEVEL: bus_rdata[LEVEL_LSB +: 3] <= pack_cnt;
                OFS_IDLE:  bus_rdata[IDLE_W-1:0] <= idle_lim;
                OFS_STAT: begin
                    bus_rdata[STAT_READY] <= !fifo_empty;
                    bus_rdata[STAT_OVR]   <= ovr_q;
                    bus_rdata[STAT_STALE] <= stale_q;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_packer_chk.sv
module uart_rx_packer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic       fifo_push,
    input logic       fifo_pop,
    input logic [2:0] pack_cnt,
    input logic       stale_evt,
    input logic       armed,
    input logic       cmd_rst,
    input logic       cmd_force,
    input logic       rearm
);
    assert_no_push_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_push);

    assert_no_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    assert_level_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pack_cnt <= 3'd4);

    assert_stale_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stale_evt && !cmd_rst && !rearm) |=> !armed);

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> (pack_cnt == 3'd0 && fifo_empty && armed));

    assert_force_pushes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_force && !cmd_rst && pack_cnt != 3'd0 && !fifo_full) |=> !fifo_empty);

endmodule

bind uart_rx_packer uart_rx_packer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop), .pack_cnt(pack_cnt),
    .stale_evt(stale_evt), .armed(armed), .cmd_rst(cmd_rst),
    .cmd_force(cmd_force), .rearm(rearm)
);

// File: tb/uart_rx_packer_test.sv
module uart_rx_packer_test;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 16;

    localparam logic [8:0] A_REARM = 9'h034;
    localparam logic [8:0] A_IDLE  = 9'h038;
    localparam logic [8:0] A_LEVEL = 9'h050;
    localparam logic [8:0] A_STAT  = 9'h0A4;
    localparam logic [8:0] A_CMD   = 9'h0A8;
    localparam logic [8:0] A_DATA  = 9'h140;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int total = 0, bad = 0;
    logic [7:0] exp_q[$];
    logic [31:0] v;

    uart_rx_packer #(.CLKS_PER_BIT(CPB)) uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic stop_ok);
        rxd = 1'b0; tick(CPB);
        for (int i = 0; i < 8; i++) begin rxd = b[i]; tick(CPB); end
        rxd = stop_ok; tick(CPB);
        rxd = 1'b1; tick(CPB);
    endtask

    task automatic send_acc(input logic [7:0] b);
        send(b, 1'b1);
        exp_q.push_back(b);
    endtask

    // Expected word: n oldest bytes, lowest lane first, upper lanes zero
    task automatic expect_word(input int n, input string req);
        logic [31:0] w;
        logic [31:0] got;
        w = '0;
        for (int i = 0; i < n; i++) w[8*i +: 8] = exp_q.pop_front();
        rd(A_DATA, got);
        check(req, got, w);
    endtask

    function automatic logic [31:0] lvl(input int n);
        return 32'(n) << 7;
    endfunction

    initial begin
        void'($urandom(32'd2024));
        tick(4); rst_n = 1'b1; tick(2);

        // Reset state
        rd(A_STAT, v);  check("R2 reset status", v, 32'h0);
        rd(A_LEVEL, v); check("R4 reset level", v, 32'h0);
        rd(A_DATA, v);  check("R3 reset empty read", v, 32'h0);

        // Byte order
        send_acc(8'h11); send_acc(8'h22); send_acc(8'h33); send_acc(8'h44);
        tick(2);
        rd(A_STAT, v); check("R2 ready after word", v, 32'h1);
        rd(A_LEVEL, v); check("R12 level drained", v, 32'h0);
        expect_word(4, "R1 lane order");
        rd(A_STAT, v); check("R2 ready clears", v, 32'h0);

        // Partial level and forced stale
        send_acc(8'($urandom)); send_acc(8'($urandom));
        rd(A_LEVEL, v); check("R4 level two", v, lvl(2));
        rd(A_STAT, v);  check("R2 no word yet", v, 32'h0);
        wr(A_CMD, 32'h400);
        rd(A_STAT, v);  check("R5 stale flushes", v, 32'h21);
        expect_word(2, "R5 zero fill");
        rd(A_LEVEL, v); check("R5 level zero", v, 32'h0);

        // Disarmed drop, re-arm
        send(8'h77, 1'b1);
        rd(A_LEVEL, v); check("R8 dropped when disarmed", v, 32'h0);
        rd(A_STAT, v);  check("R8 nothing queued", v, 32'h20);
        wr(A_REARM, 32'h7);
        send_acc(8'h5C);
        rd(A_LEVEL, v); check("R8 rearmed accepts", v, lvl(1));
        wr(A_CMD, 32'h80);
        rd(A_STAT, v);  check("R6 stale cleared", v, 32'h0);
        wr(A_CMD, 32'h400);
        expect_word(1, "R5 single byte");
        wr(A_CMD, 32'h80); wr(A_REARM, 32'h7);

        // Empty read has no effect
        send_acc(8'hA1); send_acc(8'hB2); send_acc(8'hC3);
        rd(A_DATA, v);  check("R3 empty read zero", v, 32'h0);
        rd(A_LEVEL, v); check("R3 level untouched", v, lvl(3));
        send_acc(8'hD4); tick(2);
        expect_word(4, "R3 pop word");
        rd(A_DATA, v);  check("R3 empty again", v, 32'h0);

        // Framing error
        send(8'h5A, 1'b0);
        rd(A_LEVEL, v); check("R11 bad stop dropped", v, 32'h0);
        for (int i = 0; i < 4; i++) send_acc(8'($urandom));
        tick(2);
        expect_word(4, "R11 lsb first");

        // Receiver reset
        send_acc(8'h01); send_acc(8'h02);
        wr(A_CMD, 32'h10);
        exp_q.delete();
        rd(A_LEVEL, v); check("R9 level cleared", v, 32'h0);
        rd(A_STAT, v);  check("R9 status cleared", v, 32'h0);

        // Overrun and deferred push of a full buffer
        for (int i = 0; i < 68; i++) send_acc(8'($urandom));
        rd(A_LEVEL, v); check("R12 buffer held full", v, lvl(4));
        rd(A_STAT, v);  check("R7 no overrun yet", v, 32'h1);
        send(8'hEE, 1'b1);
        rd(A_STAT, v);  check("R7 overrun set", v, 32'h11);
        for (int i = 0; i < 16; i++) expect_word(4, "R7 fifo contents");
        tick(2);
        expect_word(4, "R12 buffer moved after space");
        rd(A_STAT, v);  check("R7 flag kept", v, 32'h10);
        wr(A_CMD, 32'h30);
        rd(A_STAT, v);  check("R7 overrun cleared", v, 32'h0);

        // Automatic stale on idle
        wr(A_IDLE, 32'h2);
        send_acc(8'h91); send_acc(8'h92); send_acc(8'h93);
        rd(A_LEVEL, v); check("R10 not yet stale", v, lvl(3));
        tick(2 * 10 * CPB + 10);
        rd(A_STAT, v);  check("R10 auto stale", v, 32'h21);
        expect_word(3, "R10 zero fill");
        wr(A_IDLE, 32'h0); wr(A_CMD, 32'h80); wr(A_REARM, 32'h7);

        // Random packing rounds
        for (int r = 0; r < 12; r++) begin
            int n;
            n = 1 + int'($urandom % 7);
            for (int i = 0; i < n; i++) send_acc(8'($urandom));
            tick(2);
            if (n % 4 != 0) wr(A_CMD, 32'h400);
            for (int k = n; k > 0; k -= 4) expect_word((k > 4) ? 4 : k, "R1 random packing");
            rd(A_STAT, v); check("R2 drained", v & 32'h1, 32'h0);
            wr(A_CMD, 32'h80); wr(A_REARM, 32'h7);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule